// File: doc/BRIEF.md
# Parallel-Write Seven-Segment Digit Latch Bank

This block is the host-facing write port and the per-digit segment storage of a triplexed LCD driver. A host places a digit address, a four-bit character code and two annunciator bits on parallel inputs and pulses an active-low select line. When the select line returns high, the block captures the inputs. An internal one-shot enable then decodes the character code into seven segment states. It writes the resulting nine-bit word into the latch of the addressed digit. All other digits keep their contents.

The latched words leave the block as three three-bit segment lines per digit, ready for a display sequencer that scans three backplane phases. A build-time parameter picks the character font: hexadecimal, or a numeric font with a few letters and signs. The select strobe is a plain control pin and has no back-pressure. A strobe that arrives while the one-shot is still running is discarded, and a one-cycle flag reports it. The host must therefore space its strobes by at least the minimum gap given below.

Top module: `lcd_triplex_wr`

## Requirements
- R1: After reset every bit of `seg_o` is 0 (all segments and annunciators off) and `drop_o` is 0.
- R2: Inputs are captured only at the clock edge where `sel_n_i` is first sampled high after having been sampled low. The new word appears on `seg_o` after the next clock edge. Address, code and annunciator values at any other time, including while `sel_n_i` stays low, have no effect.
- R3: A write changes only the nine bits of the addressed digit (address value `i` selects digit `i`). All other digits keep their stored words.
- R4: Digit `i` occupies `seg_o[9*i+8 : 9*i]`. Line 0 is bits 0..2 = (b, c, an1), line 1 is bits 3..5 = (a, g, d) and line 2 is bits 6..8 = (f, e, an2). Within each line the lowest bit is backplane phase 1 and the highest is phase 3. A 1 means ON.
- R5: With `FONT_HEX`=0, codes 0..9 show the decimal digits. Code 10 lights only g (minus). Code 11 shows E (a,d,e,f,g), code 12 shows H (b,c,e,f,g), code 13 shows L (d,e,f) and code 14 shows P (a,b,e,f,g). Code 15 lights no segment.
- R6: With `FONT_HEX`=1, codes 0..9 show the same digits as R5. Codes 10..15 show A (a,b,c,e,f,g), b (c,d,e,f,g), C (a,d,e,f), d (b,c,d,e,g), E (a,d,e,f,g) and F (a,e,f,g).
- R7: `ann_i[0]` drives annunciator an1 and `ann_i[1]` drives an2, independently of the code and of each other. A 1 means ON.
- R8: A capture edge that falls while the write pulse of the previous strobe is still active (within `PULSE_CYC` edges after it) is ignored. No latch changes for it, and `drop_o` is 1 for the cycle after that edge.
- R9: A capture edge `PULSE_CYC`+1 clock edges after the previous accepted one is accepted normally, with `drop_o` staying 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low write select; the low-to-high return captures the inputs |
| addr_i | input | 3 | Digit address |
| code_i | input | 4 | Character code |
| ann_i | input | 2 | Annunciator controls, bit 0 = an1, bit 1 = an2 |
| seg_o | output | 72 | Latched segment lines, nine bits per digit |
| drop_o | output | 1 | One-cycle flag: a strobe was discarded |

## Verification
The sweep writes every digit address with every character code and every annunciator pair. Both font builds run side by side on the same inputs, and the whole 72-bit output is compared after each write. This separates the two fonts, exposes packing or phase-order errors in each line, and catches writes that spill into a neighbouring digit. Separate sequences hold the select low while the inputs change, which distinguishes capture at the return edge from level-sensitive capture. Strobes spaced one cycle too close and exactly at the minimum gap distinguish a correct drop window from one that is too short or too long.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  localparam int CODE_W = 4;
  localparam int ANN_W  = 2;
  localparam int WORD_W = 9;

  typedef struct packed {
    logic g;
    logic f;
    logic e;
    logic d;
    logic c;
    logic b;
    logic a;
  } seg7_t;

  // characters common to both fonts and the hexadecimal letters
  function automatic seg7_t font_hex(input logic [CODE_W-1:0] code);
    logic [6:0] v;
    case (code)
      4'h0: v = 7'b0111111;
      4'h1: v = 7'b0000110;
      4'h2: v = 7'b1011011;
      4'h3: v = 7'b1001111;
      4'h4: v = 7'b1100110;
      4'h5: v = 7'b1101101;
      4'h6: v = 7'b1111101;
      4'h7: v = 7'b0000111;
      4'h8: v = 7'b1111111;
      4'h9: v = 7'b1101111;
      4'hA: v = 7'b1110111;
      4'hB: v = 7'b1111100;
      4'hC: v = 7'b0111001;
      4'hD: v = 7'b1011110;
      4'hE: v = 7'b1111001;
      default: v = 7'b1110001;
    endcase
    return seg7_t'(v);
  endfunction

  // numeric font with sign and letters, top code blank
  function automatic seg7_t font_num(input logic [CODE_W-1:0] code);
    logic [6:0] v;
    case (code)
      4'hA: v = 7'b1000000;
      4'hB: v = 7'b1111001;
      4'hC: v = 7'b1110110;
      4'hD: v = 7'b0111000;
      4'hE: v = 7'b1110011;
      4'hF: v = 7'b0000000;
      default: v = font_hex(code);
    endcase
    return seg7_t'(v);
  endfunction

  // three lines of three phases: (b,c,an1) (a,g,d) (f,e,an2)
  function automatic logic [WORD_W-1:0] pack_lines(input seg7_t s,
                                                   input logic [ANN_W-1:0] ann);
    return {ann[1], s.e, s.f, s.d, s.g, s.a, ann[0], s.c, s.b};
  endfunction

endpackage

// File: rtl/lcdw_strobe_ctl.sv
module lcdw_strobe_ctl #(
  parameter int ADDR_W    = 3,
  parameter int CODE_W    = 4,
  parameter int ANN_W     = 2,
  parameter int PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ANN_W-1:0]  ann_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CODE_W-1:0] code_q,
  output logic [ANN_W-1:0]  ann_q,
  output logic              wr_en_o,
  output logic              drop_o
);

  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic             sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             busy;

  assign rise    = sel_n_i && !sel_q;
  assign busy    = (cnt_q != '0);
  assign wr_en_o = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b1;
      cnt_q  <= '0;
      addr_q <= '0;
      code_q <= '0;
      ann_q  <= '0;
      drop_o <= 1'b0;
    end else begin
      sel_q  <= sel_n_i;
      drop_o <= rise && busy;
      if (rise && !busy) begin
        addr_q <= addr_i;
        code_q <= code_i;
        ann_q  <= ann_i;
        cnt_q  <= CNT_W'(PULSE_CYC);
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_PULSE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !busy) |=> wr_en_o) else $error("write pulse missing"); // R2

  AST_DROP_KEEPS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |-> ($stable(addr_q) && $stable(code_q) && $stable(ann_q)))
    else $error("dropped strobe changed captured inputs"); // R8

endmodule

// File: rtl/lcdw_font_dec.sv
module lcdw_font_dec
  import lcdw_pkg::*;
#(
  parameter bit FONT_HEX = 1'b0
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [ANN_W-1:0]  ann_i,
  output logic [WORD_W-1:0] word_o
);

  seg7_t seg;

  generate
    if (FONT_HEX) begin : g_hex
      assign seg = font_hex(code_i);
    end else begin : g_num
      assign seg = font_num(code_i);
      always_comb begin
        if (code_i == 4'hF)
          AST_NUM_BLANK: assert (word_o[5:3] == 3'b000 && word_o[7:6] == 2'b00 &&
                                 word_o[1:0] == 2'b00)
            else $error("top code not blank"); // R5
      end
    end
  endgenerate

  assign word_o = pack_lines(seg, ann_i);

endmodule

// File: rtl/lcdw_latch_bank.sv
module lcdw_latch_bank #(
  parameter int NUM_DIGITS = 8,
  parameter int ADDR_W     = 3,
  parameter int WORD_W     = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W-1:0]            word_i,
  output logic [NUM_DIGITS*WORD_W-1:0] seg_o
);

  logic [NUM_DIGITS-1:0] wr_vec;

  generate
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
      logic [WORD_W-1:0] word_q;

      assign wr_vec[i] = wr_en_i && (addr_i == ADDR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (wr_vec[i]) begin
          word_q <= word_i;
        end
      end

      assign seg_o[i*WORD_W +: WORD_W] = word_q;
    end
  endgenerate

  AST_ONE_DIGIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)) else $error("several digits written"); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(seg_o)) else $error("latch changed without pulse"); // R3

endmodule

// File: rtl/lcd_triplex_wr.sv
module lcd_triplex_wr
  import lcdw_pkg::*;
#(
  parameter int NUM_DIGITS = 8,
  parameter int ADDR_W     = 3,
  parameter int PULSE_CYC  = 2,
  parameter bit FONT_HEX   = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_n_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [CODE_W-1:0]            code_i,
  input  logic [ANN_W-1:0]             ann_i,
  output logic [NUM_DIGITS*WORD_W-1:0] seg_o,
  output logic                         drop_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [CODE_W-1:0] code_q;
  logic [ANN_W-1:0]  ann_q;
  logic              wr_en;
  logic [WORD_W-1:0] word;

  lcdw_strobe_ctl #(
    .ADDR_W   (ADDR_W),
    .CODE_W   (CODE_W),
    .ANN_W    (ANN_W),
    .PULSE_CYC(PULSE_CYC)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n_i(sel_n_i),
    .addr_i (addr_i),
    .code_i (code_i),
    .ann_i  (ann_i),
    .addr_q (addr_q),
    .code_q (code_q),
    .ann_q  (ann_q),
    .wr_en_o(wr_en),
    .drop_o (drop_o)
  );

  lcdw_font_dec #(
    .FONT_HEX(FONT_HEX)
  ) u_dec (
    .code_i(code_q),
    .ann_i (ann_q),
    .word_o(word)
  );

  lcdw_latch_bank #(
    .NUM_DIGITS(NUM_DIGITS),
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en_i(wr_en),
    .addr_i (addr_q),
    .word_i (word),
    .seg_o  (seg_o)
  );

  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_n |=> (seg_o == '0 && !drop_o)) else $error("not dark in reset"); // R1

endmodule

// File: tb/lcd_triplex_wr_tb_top.sv
`timescale 1ns/1ps
module lcd_triplex_wr_tb_top;

  localparam int ND = 8;
  localparam int WW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic [2:0] addr = '0;
  logic [3:0] code = '0;
  logic [1:0] ann = '0;
  logic [ND*WW-1:0] seg_b, seg_h;
  logic drop_b, drop_h;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [WW-1:0] exp_b [ND];
  logic [WW-1:0] exp_h [ND];

  always #2 clk = ~clk;

  lcd_triplex_wr #(.FONT_HEX(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .addr_i(addr),
    .code_i(code), .ann_i(ann), .seg_o(seg_b), .drop_o(drop_b));

  lcd_triplex_wr #(.FONT_HEX(1'b1)) dut_hex_i (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .addr_i(addr),
    .code_i(code), .ann_i(ann), .seg_o(seg_h), .drop_o(drop_h));

  // glyphs as lists of lit segment letters
  function automatic string glyph(int c, bit hex);
    string d[10] = '{"abcdef", "bc", "abdeg", "abcdg", "bcfg",
                     "acdfg", "acdefg", "abc", "abcdefg", "abcdfg"};
    string h[6]  = '{"abcefg", "cdefg", "adef", "bcdeg", "adefg", "aefg"};
    string n[6]  = '{"g", "adefg", "bcefg", "def", "abefg", ""};
    if (c < 10) return d[c];
    return hex ? h[c-10] : n[c-10];
  endfunction

  function automatic bit has(string s, byte ch);
    for (int i = 0; i < s.len(); i++) if (s[i] == ch) return 1'b1;
    return 1'b0;
  endfunction

  // R4 layout: b c an1 | a g d | f e an2, low bit first
  function automatic logic [WW-1:0] model(int c, int a, bit hex);
    string s = glyph(c, hex);
    return {a[1], has(s, "e"), has(s, "f"), has(s, "d"), has(s, "g"),
            has(s, "a"), a[0], has(s, "c"), has(s, "b")};
  endfunction

  function automatic logic [ND*WW-1:0] flat(bit hex);
    logic [ND*WW-1:0] v;
    for (int i = 0; i < ND; i++) v[i*WW +: WW] = hex ? exp_h[i] : exp_b[i];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [ND*WW-1:0] act, logic [ND*WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_both(string req);
    chk(seg_b === flat(1'b0), {req, " num font"}, seg_b, flat(1'b0));
    chk(seg_h === flat(1'b1), {req, " hex font"}, seg_h, flat(1'b1));
  endtask

  task automatic set_model(int d, int c, int a);
    exp_b[d] = model(c, a, 1'b0);
    exp_h[d] = model(c, a, 1'b1);
  endtask

  task automatic do_write(int d, int c, int a);
    @(negedge clk);
    addr = 3'(d); code = 4'(c); ann = 2'(a); sel_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1;
    set_model(d, c, a);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin exp_b[i] = '0; exp_h[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_both("R1 reset");
    chk({drop_b, drop_h} == 2'b00, "R1 drop after reset", {70'd0, drop_b, drop_h}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_both("R1 after release");

    // exhaustive sweep: R3 R4 R5 R6 R7
    for (int d = 0; d < ND; d++)
      for (int c = 0; c < 16; c++)
        for (int a = 0; a < 4; a++) begin
          do_write(d, c, a);
          chk_both("R3 R4 R5 R6 R7 sweep");
        end

    // R2: inputs changing while select high or held low have no effect
    @(negedge clk);
    addr = 3'd5; code = 4'd8; ann = 2'd3;
    repeat (3) @(negedge clk);
    chk_both("R2 select idle high");
    sel_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      addr = 3'(k); code = 4'(k + 2); ann = 2'(k);
      chk_both("R2 select held low");
    end
    addr = 3'd6; code = 4'd2; ann = 2'd1;
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);  // capture edge passed, write edge not yet
    chk_both("R2 not yet written");
    addr = 3'd1; code = 4'd9; ann = 2'd2;
    set_model(6, 2, 1);
    @(negedge clk);
    chk_both("R2 written one edge after capture");

    // R8: second strobe inside the pulse window
    @(negedge clk);
    addr = 3'd0; code = 4'd3; ann = 2'd0; sel_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1;
    set_model(0, 3, 0);
    @(negedge clk);
    addr = 3'd7; code = 4'd1; ann = 2'd3; sel_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    chk({drop_b, drop_h} == 2'b11, "R8 drop flag", {70'd0, drop_b, drop_h}, {70'd0, 2'b11});
    @(negedge clk);
    chk({drop_b, drop_h} == 2'b00, "R8 drop one cycle", {70'd0, drop_b, drop_h}, '0);
    repeat (2) @(negedge clk);
    chk_both("R8 dropped strobe not written");

    // R9: strobe at exactly the minimum gap is accepted
    @(negedge clk);
    addr = 3'd4; code = 4'd12; ann = 2'd2; sel_n = 1'b0;
    @(negedge clk);
    sel_n = 1'b1;
    set_model(4, 12, 2);
    @(negedge clk);
    addr = 3'd2; code = 4'd14; ann = 2'd1; sel_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sel_n = 1'b1;
    set_model(2, 14, 1);
    @(negedge clk);
    chk({drop_b, drop_h} == 2'b00, "R9 no drop at gap", {70'd0, drop_b, drop_h}, '0);
    repeat (2) @(negedge clk);
    chk_both("R9 both strobes written");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule